// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single compare channel that sits beside a timer/counter. Each cycle in which the counter is enabled, it compares the running count with a programmed compare value. On equality it does three things: it drives the waveform pin as the 2-bit action field selects, it pulses a match interrupt flag for one cycle, and, when the counter's CTC top is taken from this channel, it pulses a request that clears the counter.

Software can also fire a one-cycle force strobe. The strobe applies the pin action at once, as though a match had happened. It does not touch the interrupt flag or the clear request. The strobe is honoured only while the timer runs a non-PWM waveform mode. It is a pulse and holds no state, so the channel has no stored force bit that could read back as anything but zero.

All outputs are registered. A match or force sampled at one rising edge shows on the outputs right after that edge. The counter, compare value and control fields are plain level inputs with no handshake, because the counter owner drives them every cycle and has no way to stall.

Top module: `oc_channel`

## Requirements
- R1: While reset is asserted, and right after it, `oc_pin`, `match_irq` and `ctc_clear` are all 0.
- R2: When `cnt_en` is 1 and `cnt_val` equals `cmp_val` at a rising edge, `match_irq` is 1 for exactly the cycle after that edge. With no match it is 0.
- R3: A match while `ctc_top` is 1 raises `ctc_clear` in the same cycle as `match_irq`. A match while `ctc_top` is 0 leaves `ctc_clear` at 0.
- R4: The action field `oc_mode` selects the pin action on a match: 00 holds the level, 01 toggles it, 10 drives 0 and 11 drives 1.
- R5: A `force_stb` pulse while `pwm_mode` is 0 applies the action selected by the current `oc_mode` to `oc_pin` after the same edge.
- R6: A force pulse never raises `match_irq` or `ctc_clear`, even when `ctc_top` is 1.
- R7: A force pulse while `pwm_mode` is 1 has no effect, so `oc_pin` keeps its level.
- R8: When a force pulse and a real match fall on the same edge, the action is applied once. In toggle mode the pin changes exactly once.
- R9: When `cnt_en` is 0, equal values are not a match: no flag, no clear and no pin action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter value is live this cycle |
| cnt_val | input | CNT_W | Current counter value |
| cmp_val | input | CNT_W | Compare value |
| oc_mode | input | 2 | Pin action on match or force |
| pwm_mode | input | 1 | 1 = a PWM waveform mode is active |
| ctc_top | input | 1 | 1 = this channel defines the counter top in CTC mode |
| force_stb | input | 1 | One-cycle force strobe |
| oc_pin | output | 1 | Waveform output level |
| match_irq | output | 1 | One-cycle match flag |
| ctc_clear | output | 1 | One-cycle counter clear request |

## Verification
The bench goes after the corners where a force and a match are easy to confuse.

- **Force with `ctc_top` set:** a design that routes the force through the match path would raise the flag or clear the counter here.
- **Force in PWM mode:** a design that ignores `pwm_mode` would move the pin.
- **Force and match in toggle mode on the same edge:** a design that applies both events would toggle twice, leaving the pin unchanged.
- **Equal values with `cnt_en` low:** a design that ignores the enable would flag a phantom match.
- **Hold mode:** a design with the wrong mode decode would move the pin when it should hold.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    OC_HOLD   = 2'b00,
    OC_TOGGLE = 2'b01,
    OC_CLEAR  = 2'b10,
    OC_SET    = 2'b11
  } oc_mode_e;

  function automatic logic oc_next_level(oc_mode_e mode, logic cur);
    case (mode)
      OC_TOGGLE: return ~cur;
      OC_CLEAR:  return 1'b0;
      OC_SET:    return 1'b1;
      default:   return cur;
    endcase
  endfunction
endpackage

// File: rtl/oc_match_detect.sv
module oc_match_detect #(
  parameter int CNT_W = 16
) (
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             hit
);
  always_comb hit = cnt_en && (cnt_val == cmp_val);
endmodule

// File: rtl/oc_pin_ctrl.sv
module oc_pin_ctrl
  import oc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hit,
  input  logic     force_stb,
  input  logic     pwm_mode,
  input  oc_mode_e mode,
  output logic     pin
);
  logic force_ok;
  logic apply;

  // A force and a match on the same edge merge into one action.
  always_comb begin
    force_ok = force_stb && !pwm_mode;
    apply    = hit || force_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     pin <= 1'b0;
    else if (apply) pin <= oc_next_level(mode, pin);
  end
endmodule

// File: rtl/oc_event_regs.sv
module oc_event_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic ctc_top,
  output logic irq,
  output logic clr
);
  // Only a real match reaches these registers; the force path never does.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
      clr <= 1'b0;
    end else begin
      irq <= hit;
      clr <= hit && ctc_top;
    end
  end
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [1:0]       oc_mode,
  input  logic             pwm_mode,
  input  logic             ctc_top,
  input  logic             force_stb,
  output logic             oc_pin,
  output logic             match_irq,
  output logic             ctc_clear
);
  logic     hit;
  oc_mode_e mode_q;

  always_comb mode_q = oc_mode_e'(oc_mode);

  oc_match_detect #(.CNT_W(CNT_W)) u_match (
    .cnt_en  (cnt_en),
    .cnt_val (cnt_val),
    .cmp_val (cmp_val),
    .hit     (hit)
  );

  oc_pin_ctrl u_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .force_stb (force_stb),
    .pwm_mode  (pwm_mode),
    .mode      (mode_q),
    .pin       (oc_pin)
  );

  oc_event_regs u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .ctc_top (ctc_top),
    .irq     (match_irq),
    .clr     (ctc_clear)
  );
endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] cmp_val,
  input logic [1:0]       oc_mode,
  input logic             pwm_mode,
  input logic             ctc_top,
  input logic             force_stb,
  input logic             oc_pin,
  input logic             match_irq,
  input logic             ctc_clear
);
  logic eq;
  always_comb eq = (cnt_val == cmp_val);

  p_irq_on_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && eq) |=> match_irq);

  p_no_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_en && eq) |=> !match_irq);

  p_clear_ctc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && eq && ctc_top) |=> ctc_clear);

  p_clear_needs_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctc_clear |-> match_irq);

  p_hold_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_mode == 2'b00) |=> $stable(oc_pin));

  p_force_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (force_stb && !(cnt_en && eq)) |=> (!match_irq && !ctc_clear));

  p_force_pwm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (force_stb && pwm_mode && !(cnt_en && eq)) |=> $stable(oc_pin));

  p_toggle_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_stb && !pwm_mode && cnt_en && eq && oc_mode == 2'b01)
      |=> (oc_pin != $past(oc_pin)));
endmodule

bind oc_channel oc_channel_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/oc_channel_tb.sv
`timescale 1ns/1ps
module oc_channel_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_en = 1'b0;
  logic [W-1:0] cnt_val = '0;
  logic [W-1:0] cmp_val = '0;
  logic [1:0]   oc_mode = 2'b00;
  logic         pwm_mode = 1'b0;
  logic         ctc_top = 1'b0;
  logic         force_stb = 1'b0;
  logic         oc_pin, match_irq, ctc_clear;

  typedef struct {
    logic  pin;
    logic  irq;
    logic  clr;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails = 0;
  logic model_pin = 1'b0;

  always #10 clk = ~clk;

  oc_channel #(.CNT_W(W)) u_dut (.*);

  task automatic compare(input string tag, input logic p, input logic i, input logic c);
    checks++;
    if (oc_pin !== p || match_irq !== i || ctc_clear !== c) begin
      fails++;
      $display("FAIL %s: pin/irq/clr actual %b%b%b expected %b%b%b",
               tag, oc_pin, match_irq, ctc_clear, p, i, c);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the result expected after the edge.
  task automatic drive(input logic en, input logic [W-1:0] cv, input logic [W-1:0] mv,
                       input logic [1:0] md, input logic pwm, input logic ctc,
                       input logic frc, input string tag);
    exp_t e;
    logic hit;
    @(negedge clk);
    cnt_en = en; cnt_val = cv; cmp_val = mv; oc_mode = md;
    pwm_mode = pwm; ctc_top = ctc; force_stb = frc;
    hit = en && (cv == mv);
    if (hit || (frc && !pwm)) begin
      case (md)
        2'b01:   model_pin = ~model_pin;
        2'b10:   model_pin = 1'b0;
        2'b11:   model_pin = 1'b1;
        default: model_pin = model_pin;
      endcase
    end
    e.pin = model_pin; e.irq = hit; e.clr = hit && ctc; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: one step after each rising edge, compare against the oldest expectation.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        compare(e.tag, e.pin, e.irq, e.clr);
      end
    end
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 compare("R1 in reset", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1 compare("R1 after reset", 1'b0, 1'b0, 1'b0);

    drive(1, 16'h0010, 16'h0010, 2'b11, 0, 0, 0, "R2 R4 set on match");
    drive(1, 16'h0011, 16'h0010, 2'b11, 0, 0, 0, "R2 flag drops");
    drive(1, 16'h0010, 16'h0010, 2'b01, 0, 1, 0, "R3 ctc toggle match");
    drive(1, 16'h0010, 16'h0010, 2'b01, 0, 0, 0, "R3 no clear without ctc");
    drive(0, 16'h0020, 16'h0020, 2'b01, 0, 1, 0, "R9 disabled equal");
    drive(1, 16'h0020, 16'h0020, 2'b00, 0, 1, 0, "R4 hold on match");
    drive(1, 16'hFFFF, 16'hFFFF, 2'b10, 0, 0, 0, "R4 clear on match");
    drive(1, 16'h0001, 16'h0002, 2'b11, 0, 1, 1, "R5 R6 force set ctc");
    drive(1, 16'h0001, 16'h0002, 2'b10, 1, 1, 1, "R7 force in pwm");
    drive(1, 16'h0001, 16'h0002, 2'b10, 0, 0, 1, "R5 force clear");
    drive(1, 16'h0005, 16'h0005, 2'b01, 0, 1, 1, "R8 force and match toggle");
    drive(1, 16'h0006, 16'h0005, 2'b01, 0, 0, 1, "R5 R6 force toggle");
    drive(1, 16'h0006, 16'h0005, 2'b01, 0, 0, 1, "R5 force toggle again");
    drive(0, 16'h0000, 16'h0000, 2'b00, 0, 0, 1, "R4 R6 force hold");
    drive(1, 16'h0000, 16'h0000, 2'b11, 1, 1, 0, "R2 R3 match in pwm");
    drive(1, 16'h0003, 16'h0004, 2'b11, 0, 0, 0, "R2 idle");
    @(negedge clk);
    force_stb = 1'b0; cnt_en = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule